// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Rotator

This unit produces the second ALU operand and a shifter carry-out for data-processing instructions. Its inputs are the instruction word, the value already read for the operand register, the value already read for the shift-amount register, and the current carry flag. The major class bits and bit 5 of the instruction select one of three cases. In the first, a 9-bit immediate is rotated left by a 5-bit amount. In the second, the register value is shifted by a 5-bit immediate. In the third, the register value is shifted by an amount held in a second register.

The result and the carry-out are captured in one register stage when the input valid is high. They stay unchanged while no new operand is presented. A pipeline feeds it the register-file values in the same cycle as the instruction word. It reads the ALU operand and the carry candidate one cycle later.

Top module: `opnd_shifter`

## Requirements
- R1: When instr[31:29] is 001, the operand is instr[8:0] zero-extended and rotated left by instr[13:9]. The carry-out is bit 0 of that result when the rotate amount is nonzero, and carry_in otherwise.
- R2: When instr[31:29] is 000 and instr[5] is 0, the operand is rm_val shifted by the amount in instr[13:9], with the shift type taken from instr[7:6].
- R3: When instr[31:29] is 000 and instr[5] is 1, the shift amount is rs_val[7:0]. The upper bits of rs_val have no effect.
- R4: The shift-type codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For amounts 1 to 31, the carry-out is the last bit shifted out.
- R5: A register shift by an amount of zero returns rm_val unchanged and returns carry_in as the carry-out.
- R6: A logical shift by exactly 32 gives 0, with carry rm_val[0] for a left shift and rm_val[31] for a right shift. A logical shift by more than 32 gives 0 with carry 0.
- R7: An arithmetic right shift by 32 or more gives 32 copies of rm_val[31], and rm_val[31] as the carry.
- R8: A rotate right uses the amount modulo 32. A nonzero amount that is a multiple of 32 returns rm_val unchanged, with carry rm_val[31].
- R9: For any other value of instr[31:29], the operand is rm_val and the carry-out is carry_in.
- R10: out_valid equals in_valid delayed by one clock. When in_valid is low, operand and shift_carry keep their values.
- R11: While rst_n is low, out_valid, operand and shift_carry are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operand values are present |
| instr | input | 32 | Instruction word |
| rm_val | input | XLEN | Value of the operand register |
| rs_val | input | XLEN | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is new this cycle |
| operand | output | XLEN | Registered second ALU operand |
| shift_carry | output | 1 | Registered shifter carry-out |

## Verification
The bench builds the block with its defaults: XLEN of 32 and AMT_W of 8. With these values, every register-shift amount from 0 to 255 can be reached for all four shift types. The same holds for every immediate-shift amount. The bench also sweeps all 512 immediates across all 32 rotations. This exercises the boundaries at 32 and above: zero fill, sign fill, carry from bit 0 or bit 31, and rotation by multiples of 32. These are checked against a bit-at-a-time arithmetic model.

// File: rtl/opsh_pkg.sv
`timescale 1ns/1ps
package opsh_pkg;
    localparam int INSTR_W    = 32;
    localparam int CLS_HI     = 31;
    localparam int CLS_LO     = 29;
    localparam int AMTF_HI    = 13;
    localparam int AMTF_LO    = 9;
    localparam int AMTF_W     = AMTF_HI - AMTF_LO + 1;
    localparam int KIND_HI    = 7;
    localparam int KIND_LO    = 6;
    localparam int REGSEL_BIT = 5;
    localparam int IMM_W      = 9;

    localparam logic [2:0] CLS_REG = 3'b000;
    localparam logic [2:0] CLS_IMM = 3'b001;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        SRC_IMM_SHIFT = 2'd0,
        SRC_REG_SHIFT = 2'd1,
        SRC_ROT_IMM   = 2'd2,
        SRC_PASS      = 2'd3
    } src_e;
endpackage

// File: rtl/opsh_decode.sv
`timescale 1ns/1ps
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int AMT_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    rs_val,
    output src_e               src,
    output shift_kind_e        kind,
    output logic [AMT_W-1:0]   amt,
    output logic [AMTF_W-1:0]  rot,
    output logic [IMM_W-1:0]   imm
);
    logic [2:0] cls;
    logic       unused_bits;

    assign cls  = instr[CLS_HI:CLS_LO];
    assign kind = shift_kind_e'(instr[KIND_HI:KIND_LO]);
    assign rot  = instr[AMTF_HI:AMTF_LO];
    assign imm  = instr[IMM_W-1:0];

    assign unused_bits = ^{instr[CLS_LO-1:AMTF_HI+1], rs_val[XLEN-1:AMT_W]};

    always_comb begin
        src = SRC_PASS;
        amt = '0;
        if (cls == CLS_IMM) begin
            src = SRC_ROT_IMM;
        end else if (cls == CLS_REG) begin
            if (instr[REGSEL_BIT]) begin
                src = SRC_REG_SHIFT;
                amt = rs_val[AMT_W-1:0];
            end else begin
                src = SRC_IMM_SHIFT;
                amt = AMT_W'(instr[AMTF_HI:AMTF_LO]);
            end
        end
    end
endmodule

// File: rtl/opsh_barrel.sv
`timescale 1ns/1ps
module opsh_barrel
    import opsh_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int AMT_W = 8
) (
    input  logic [XLEN-1:0]  val,
    input  logic [AMT_W-1:0] amt,
    input  shift_kind_e      kind,
    input  logic             cin,
    output logic [XLEN-1:0]  res,
    output logic             cout
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN:0]   wide_l;
    logic [XLEN:0]   wide_r;
    logic [XLEN-1:0] rot_v;
    logic [SHW-1:0]  rot_m;
    int              n;
    int              nclamp;

    always_comb begin
        n      = int'(amt);
        nclamp = (n > XLEN) ? XLEN : n;
        rot_m  = amt[SHW-1:0];
        wide_l = {1'b0, val} << nclamp;
        wide_r = {val, 1'b0} >> nclamp;
        rot_v  = (val >> rot_m) | (val << (XLEN - int'(rot_m)));
        res    = val;
        cout   = cin;
        if (n != 0) begin
            unique case (kind)
                SK_LSL: begin
                    if (n > XLEN) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = wide_l[XLEN-1:0];
                        cout = wide_l[XLEN];
                    end
                end
                SK_LSR: begin
                    if (n > XLEN) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = wide_r[XLEN:1];
                        cout = wide_r[0];
                    end
                end
                SK_ASR: begin
                    wide_r = ($signed({val, 1'b0})) >>> nclamp;
                    res    = wide_r[XLEN:1];
                    cout   = wide_r[0];
                end
                SK_ROR: begin
                    if (rot_m == '0) begin
                        res  = val;
                        cout = val[XLEN-1];
                    end else begin
                        res  = rot_v;
                        cout = rot_v[XLEN-1];
                    end
                end
                default: begin
                    res  = val;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/opsh_rotl.sv
`timescale 1ns/1ps
module opsh_rotl #(
    parameter int XLEN  = 32,
    parameter int IMMW  = 9,
    parameter int ROT_W = 5
) (
    input  logic [IMMW-1:0]  imm,
    input  logic [ROT_W-1:0] rot,
    input  logic             cin,
    output logic [XLEN-1:0]  res,
    output logic             cout
);
    logic [XLEN-1:0] stage [0:ROT_W];

    assign stage[0] = XLEN'(imm);

    for (genvar k = 0; k < ROT_W; k++) begin : g_stage
        localparam int STEP = (1 << k) % XLEN;
        if (STEP == 0) begin : g_ident
            assign stage[k+1] = stage[k];
        end else begin : g_rot
            assign stage[k+1] = rot[k] ? ((stage[k] << STEP) | (stage[k] >> (XLEN - STEP)))
                                       : stage[k];
        end
    end

    assign res  = stage[ROT_W];
    assign cout = (rot != '0) ? stage[ROT_W][0] : cin;
endmodule

// File: rtl/opnd_shifter.sv
`timescale 1ns/1ps
module opnd_shifter
    import opsh_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int AMT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [XLEN-1:0]     rm_val,
    input  logic [XLEN-1:0]     rs_val,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [XLEN-1:0]     operand,
    output logic                shift_carry
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] opnd;
        logic            cy;
    } state_t;

    state_t            state_d, state_q;
    src_e              src;
    shift_kind_e       kind;
    logic [AMT_W-1:0]  amt;
    logic [AMTF_W-1:0] rot;
    logic [IMM_W-1:0]  imm;
    logic [XLEN-1:0]   sh_res, rot_res;
    logic              sh_cy, rot_cy;

    opsh_decode #(.XLEN(XLEN), .AMT_W(AMT_W)) u_dec (
        .instr(instr), .rs_val(rs_val), .src(src), .kind(kind),
        .amt(amt), .rot(rot), .imm(imm)
    );

    opsh_barrel #(.XLEN(XLEN), .AMT_W(AMT_W)) u_bar (
        .val(rm_val), .amt(amt), .kind(kind), .cin(carry_in),
        .res(sh_res), .cout(sh_cy)
    );

    opsh_rotl #(.XLEN(XLEN), .IMMW(IMM_W), .ROT_W(AMTF_W)) u_rot (
        .imm(imm), .rot(rot), .cin(carry_in), .res(rot_res), .cout(rot_cy)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            unique case (src)
                SRC_ROT_IMM: begin
                    state_d.opnd = rot_res;
                    state_d.cy   = rot_cy;
                end
                SRC_IMM_SHIFT, SRC_REG_SHIFT: begin
                    state_d.opnd = sh_res;
                    state_d.cy   = sh_cy;
                end
                default: begin
                    state_d.opnd = rm_val;
                    state_d.cy   = carry_in;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.vld;
    assign operand     = state_q.opnd;
    assign shift_carry = state_q.cy;

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(operand) && $stable(shift_carry)));
    p_rot_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src == SRC_ROT_IMM && rot != '0) |=> (shift_carry == operand[0]));
    p_zero_amt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src == SRC_IMM_SHIFT || src == SRC_REG_SHIFT) && amt == '0)
        |=> (operand == $past(rm_val) && shift_carry == $past(carry_in)));
    p_lsl_far_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src == SRC_REG_SHIFT && kind == SK_LSL && int'(amt) > XLEN)
        |=> (operand == '0 && !shift_carry));
    p_asr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src == SRC_REG_SHIFT && kind == SK_ASR && int'(amt) >= XLEN)
        |=> (operand == {XLEN{$past(rm_val[XLEN-1])}} && shift_carry == $past(rm_val[XLEN-1])));
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src == SRC_PASS)
        |=> (operand == $past(rm_val) && shift_carry == $past(carry_in)));
endmodule

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        shift_carry;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    opnd_shifter #(.XLEN(32), .AMT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in),
        .out_valid(out_valid), .operand(operand), .shift_carry(shift_carry)
    );

    logic [31:0] pats [0:7] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000,
                                32'hFFFF_FFFF, 32'h1234_5678, 32'hC000_0003, 32'h4000_0000};

    // Bit-at-a-time model of R1..R9; returns {carry, operand}.
    function automatic logic [32:0] model(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs, logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (ins[31:29] == 3'b001) begin
            v = {23'b0, ins[8:0]};
            n = int'(ins[13:9]);
            for (int i = 0; i < n; i++) v = {v[30:0], v[31]};
            if (n != 0) c = v[0];
        end else if (ins[31:29] == 3'b000) begin
            v = rm;
            n = ins[5] ? int'(rs[7:0]) : int'(ins[13:9]);
            case (ins[7:6])
                2'b00: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
                2'b01: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
                2'b10: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
                default: begin
                    for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
                    if (n != 0 && n % 32 == 0) c = v[31];
                end
            endcase
        end else begin
            v = rm;
        end
        return {c, v};
    endfunction

    function automatic string tag(logic [31:0] ins, logic [31:0] rs);
        int n;
        if (ins[31:29] == 3'b001) return "R1";
        if (ins[31:29] != 3'b000) return "R9";
        n = ins[5] ? int'(rs[7:0]) : int'(ins[13:9]);
        if (n == 0) return "R5";
        if (n >= 32) begin
            if (ins[7:6] == 2'b10) return "R7";
            if (ins[7:6] == 2'b11) return "R8";
            return "R6";
        end
        return ins[5] ? "R3" : "R4";
    endfunction

    // Drive one vector, then compare one cycle later (away from the edge).
    task automatic apply(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs, logic ci);
        logic [32:0] exp;
        instr = ins; rm_val = rm; rs_val = rs; carry_in = ci; in_valid = 1'b1;
        exp = model(ins, rm, rs, ci);
        @(negedge clk);
        nvec++;
        if (!out_valid || operand != exp[31:0] || shift_carry != exp[32]) begin
            nbad++;
            $display("FAIL %s/R10 ins=%h rm=%h rs=%h ci=%b: got v=%b op=%h c=%b exp v=1 op=%h c=%b",
                     tag(ins, rs), ins, rm, rs, ci, out_valid, operand, shift_carry, exp[31:0], exp[32]);
        end
    endtask

    task automatic check(string req, logic [33:0] act, logic [33:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", {out_valid, shift_carry, operand}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {out_valid, shift_carry, operand}, 34'h0);

        // R2/R4/R5: register shifted by the 5-bit field, all types, all amounts
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a++)
                for (int p = 0; p < 8; p++)
                    for (int c = 0; c < 2; c++)
                        apply({3'b000, 15'h5A3C ^ 15'(p), 5'(a), 1'b0, 2'(k), 1'b0, 5'(p)},
                              pats[p], pats[7 - p], 1'(c));

        // R3/R6/R7/R8: register-held amounts 0..255, upper rs bits junk
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                for (int p = 0; p < 4; p++)
                    apply({3'b000, 15'h1F0F, 5'(a + p), 1'b0, 2'(k), 1'b1, 5'(a)},
                          pats[(p * 3 + a) % 8], {24'(pats[p][31:8] ^ 24'(a)), 8'(a)}, 1'((a + p) & 1));

        // R1: every immediate at every rotation
        for (int r = 0; r < 32; r++)
            for (int i = 0; i < 512; i++)
                apply({3'b001, 15'h2AAA, 5'(r), 9'(i)}, pats[i % 8], pats[r % 8], 1'(i & 1));

        // R9: other major classes forward Rm and the carry
        for (int cl = 2; cl < 8; cl++)
            for (int p = 0; p < 8; p++)
                apply({3'(cl), 29'h0ABC_DEF1 ^ 29'(p)}, pats[p], pats[p] ^ 32'hFFFF, 1'(p & 1));

        // R10: with in_valid low, changed inputs leave the outputs held
        begin
            logic [33:0] held;
            apply({3'b000, 15'h0, 5'd4, 1'b0, 2'b00, 1'b0, 5'd0}, 32'h0F00_0001, 32'h0, 1'b0);
            held = {1'b0, shift_carry, operand};
            in_valid = 1'b0; instr = 32'h2000_3FFF; rm_val = 32'hDEAD_BEEF; carry_in = 1'b1;
            @(negedge clk);
            check("R10", {out_valid, shift_carry, operand}, held);
            @(negedge clk);
            check("R10", {out_valid, shift_carry, operand}, held);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule